// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash. A client hands it one request at a time: write a word, clear a sector, clear a block or clear the whole array. The sequencer emits the unlock and command writes that the flash expects, using a simple synchronous bus master port with separate write and read strobes and an acknowledge. Each strobe is held until the acknowledge arrives, and at least one idle cycle follows every transaction.

Once the final command write is acknowledged, the block reads the target location again and again. While the flash is busy, bit 6 of each read differs from the one before. When two reads in a row agree on bit 6, the block also guards against a read that raced the end of the operation. It takes two further reads, and both must equal the stable word in full. Only then does it report success.

Each operation kind has its own cycle-count time budget. If the budget runs out first, the block reports completion with an error flag set rather than waiting forever.

Top module: `nor_op_sequencer`

## Requirements
- R1: A word program (req_op = 00) issues exactly four writes: 0x00AA to address 0x5555, 0x0055 to 0x2AAA, 0x00A0 to 0x5555, then req_data to req_addr. Command writes carry zero in every data bit above bit 7.
- R2: Every clear request issues exactly six writes. The first five are 0x00AA@0x5555, 0x0055@0x2AAA, 0x0080@0x5555, 0x00AA@0x5555 and 0x0055@0x2AAA.
- R3: The sixth write of a clear request depends on req_op. Sector (01) writes 0x0030 to req_addr, block (10) writes 0x0050 to req_addr, and whole array (11) writes 0x0010 to 0x5555.
- R4: A strobe, with its address and write data, stays unchanged until the cycle in which bus_ack is seen. The cycle after an acknowledged transaction has both strobes low. bus_wr and bus_rd are never high together.
- R5: After the final write, only reads of req_addr are issued. A read whose bit 6 differs from the previous read's bit 6 means the operation is still running, and polling goes on.
- R6: Two consecutive reads that agree on bit 6 must be followed by two more reads equal in all bits to the second of them. If the flash is idle from the start, this takes exactly four reads. Any mismatch restarts polling, and success is reported only after the full confirmation.
- R7: A cycle counter starts at the final write's acknowledge. Before each read, if it has reached the limit for the request kind (program, sector, block or whole array), the block finishes with error = 1 and issues no further reads.
- R8: req_ready is high only in the idle state, and a request is taken when req_valid and req_ready are both high. req_valid pulses during an operation add no bus writes.
- R9: done is a single-cycle pulse followed by req_ready high. error is high only together with done and is 0 on a confirmed success.
- R10: While reset is applied and just after it, req_ready = 1 and done, error, bus_wr and bus_rd are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 00 program, 01 sector clear, 10 block clear, 11 whole-array clear |
| req_addr | input | ADDR_W | Target word, sector or block address |
| req_data | input | DATA_W | Word to program |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion was a timeout (valid with done) |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Transaction acknowledge |

## Verification
The embedded properties watch the bus discipline on every cycle: strobes stay stable until acknowledged, a gap follows each transaction, the two strobes never overlap, done is a single pulse that is followed by readiness, error never appears without done, and the timeout branch always ends in an error completion. Only the bench scenarios can show that the command words and addresses come in the right order for each request kind. The same holds for the number of reads needed for each pattern of toggling answers, and for the restart of polling after a racing read that changes one bit but not bit 6. The bench also measures how many reads each timeout budget allows.

// File: rtl/nor_op_sequencer.sv
module nor_op_sequencer #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 10000,
  parameter int SECT_CYC = 12500000,
  parameter int BLK_CYC  = 12500000,
  parameter int CHIP_CYC = 50000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              error,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  localparam int MAX_E   = (SECT_CYC > BLK_CYC) ? SECT_CYC : BLK_CYC;
  localparam int MAX_EC  = (MAX_E > CHIP_CYC) ? MAX_E : CHIP_CYC;
  localparam int MAX_CYC = (MAX_EC > PROG_CYC) ? MAX_EC : PROG_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(15'h5555);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(15'h2AAA);
  localparam logic [1:0] OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WGAP, S_RGAP, S_RD, S_DONE} st_t;

  st_t               st;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdat, prev;
  logic [2:0]        step;
  logic              have_prev, err;
  logic [1:0]        conf;
  logic [TMR_W-1:0]  tmr, limit;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_code;

  wire is_prog   = (op == OP_PROG);
  wire data_step = is_prog && (step == 3'd3);
  wire last_step = is_prog ? (step == 3'd3) : (step == 3'd5);

  always_comb begin
    case (op)
      2'd0:    limit = TMR_W'(PROG_CYC);
      2'd1:    limit = TMR_W'(SECT_CYC);
      2'd2:    limit = TMR_W'(BLK_CYC);
      default: limit = TMR_W'(CHIP_CYC);
    endcase
  end

  always_comb begin
    cmd_addr = A_LO;
    cmd_code = 8'hAA;
    case (step)
      3'd1, 3'd4: begin cmd_addr = A_HI; cmd_code = 8'h55; end
      3'd2:       cmd_code = is_prog ? 8'hA0 : 8'h80;
      3'd5: begin
        cmd_addr = (op == OP_CHIP) ? A_LO : addr;
        cmd_code = (op == OP_CHIP) ? 8'h10 : (op == OP_SECT) ? 8'h30 : 8'h50;
      end
      default: ;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign error     = done && err;
  assign bus_wr    = (st == S_WR);
  assign bus_rd    = (st == S_RD);
  assign bus_addr  = (bus_rd || data_step) ? addr : cmd_addr;
  assign bus_wdata = data_step ? wdat : DATA_W'(cmd_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; addr <= '0; wdat <= '0; prev <= '0;
      step <= '0; have_prev <= 1'b0; err <= 1'b0; conf <= '0; tmr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op; addr <= req_addr; wdat <= req_data;
          step <= '0; err <= 1'b0; st <= S_WR;
        end
        S_WR: if (bus_ack) begin
          if (last_step) begin
            st <= S_RGAP; tmr <= '0; have_prev <= 1'b0; conf <= '0;
          end else begin
            step <= step + 3'd1; st <= S_WGAP;
          end
        end
        S_WGAP: st <= S_WR;
        S_RGAP: begin
          tmr <= tmr + 1'b1;
          if (tmr >= limit) begin err <= 1'b1; st <= S_DONE; end
          else st <= S_RD;
        end
        S_RD: begin
          tmr <= tmr + 1'b1;
          if (bus_ack) begin
            st <= S_RGAP;
            if (conf == 2'd0) begin
              if (have_prev && (bus_rdata[6] == prev[6])) conf <= 2'd1;
              prev <= bus_rdata; have_prev <= 1'b1;
            end else if (bus_rdata == prev) begin
              if (conf == 2'd2) st <= S_DONE;
              else conf <= 2'd2;
            end else begin
              conf <= 2'd0; prev <= bus_rdata;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd));
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr)));
  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_ack) |=> (!bus_wr && !bus_rd));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_wr && !bus_rd));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n) error |-> done);
  p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RGAP && tmr >= limit) |=> (done && error && !bus_rd));

endmodule

// File: tb/nor_op_sequencer_test.sv
`timescale 1ns/1ps
module nor_op_sequencer_test;
  localparam int AW = 20, DW = 16;
  localparam int LP = 30, LS = 45, LB = 60, LC = 90;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, error, bus_wr, bus_rd, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int errors = 0, checks = 0;
  bit finished = 0;

  // flash model configuration, driven by tasks only
  int  m_busy = 0;
  bit  m_forever = 0, m_trans = 0, clr = 0;
  logic [DW-1:0] m_final = '0;
  logic [AW-1:0] m_addr = '0;

  // model state, driven by the model process only
  logic [AW-1:0] wa [0:7];
  logic [DW-1:0] wd [0:7];
  int wcnt, rcnt;
  bit addr_bad;

  always #2 clk = ~clk;

  nor_op_sequencer #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(LP), .SECT_CYC(LS),
                     .BLK_CYC(LB), .CHIP_CYC(LC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
    .error(error), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  function automatic logic [DW-1:0] answer(int i);
    logic [DW-1:0] v;
    if (m_forever || i < m_busy) begin
      v = m_final ^ 16'h0080;
      v[6] = i[0];
    end else if (m_trans && i == m_busy) v = m_final ^ 16'h0080;
    else v = m_final;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      bus_ack <= 1'b0; bus_rdata <= '0; wcnt <= 0; rcnt <= 0; addr_bad <= 1'b0;
    end else begin
      bus_ack <= (bus_wr || bus_rd) && !bus_ack;
      if ((bus_wr || bus_rd) && !bus_ack) begin
        if (bus_wr) begin
          if (wcnt < 8) begin wa[wcnt] <= bus_addr; wd[wcnt] <= bus_wdata; end
          wcnt <= wcnt + 1;
        end else begin
          bus_rdata <= answer(rcnt);
          rcnt <= rcnt + 1;
          if (bus_addr != m_addr) addr_bad <= 1'b1;
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_a(int op, int i, logic [AW-1:0] a);
    if (i == 1 || i == 4) return AW'(15'h2AAA);
    if (op == 0 && i == 3) return a;
    if (i == 5 && op != 3) return a;
    return AW'(15'h5555);
  endfunction

  function automatic logic [DW-1:0] exp_d(int op, int i, logic [DW-1:0] d);
    if (i == 0 || i == 3) return (op == 0 && i == 3) ? d : 16'h00AA;
    if (i == 1 || i == 4) return 16'h0055;
    if (i == 2) return (op == 0) ? 16'h00A0 : 16'h0080;
    return (op == 1) ? 16'h0030 : (op == 2) ? 16'h0050 : 16'h0010;
  endfunction

  task automatic run_op(int op, logic [AW-1:0] a, logic [DW-1:0] d, int k,
                        logic [DW-1:0] fin, bit trans, bit forever_busy,
                        int exp_reads, bit exp_err);
    int nw = (op == 0) ? 4 : 6;
    bit seen = 0, seen_err = 0;
    @(negedge clk);
    m_busy = k; m_final = fin; m_trans = trans; m_forever = forever_busy; m_addr = a;
    clr = 1;
    @(negedge clk);
    clr = 0;
    req_valid = 1; req_op = 2'(op); req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R8", "ready low while busy", req_ready, 0);
    // stray request during the operation must be ignored
    req_valid = 1; req_op = 2'(3 - op);
    repeat (4) @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (done) begin seen = 1; seen_err = error; end
      else if (error) check(0, "R9", "error without done", 1, 0);
    end
    check(seen, "R9", "done observed", seen, 1);
    check(seen_err == exp_err, exp_err ? "R7" : "R9", "error flag", seen_err, exp_err);
    check(wcnt == nw, "R8", "write count", wcnt, nw);
    for (int i = 0; i < nw && i < wcnt; i++) begin
      check(wa[i] == exp_a(op, i, a), (i < 5 && op != 0) ? "R2" : (op == 0) ? "R1" : "R3",
            $sformatf("write %0d addr", i), wa[i], exp_a(op, i, a));
      check(wd[i] == exp_d(op, i, d), (i < 5 && op != 0) ? "R2" : (op == 0) ? "R1" : "R3",
            $sformatf("write %0d data", i), wd[i], exp_d(op, i, d));
    end
    check(rcnt == exp_reads, exp_err ? "R7" : "R6", "read count", rcnt, exp_reads);
    check(!addr_bad, "R5", "poll address", addr_bad, 0);
    @(negedge clk);
    check(!done && req_ready, "R9", "done single pulse then ready", done, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R10", "ready in reset", req_ready, 1);
    check(!done && !error && !bus_wr && !bus_rd, "R10", "quiet in reset",
          {done, error, bus_wr, bus_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1 && !bus_wr && !bus_rd, "R10", "idle after reset", req_ready, 1);

    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 6; k++)
        for (int f6 = 0; f6 < 2; f6++) begin
          logic [AW-1:0] a = AW'(20'h12345 + op * 20'h1111 + k * 20'h0203);
          logic [DW-1:0] d = 16'h1234 ^ DW'(k * 16'h0111 + op);
          logic [DW-1:0] fin = d ^ 16'h5A5A;
          int er;
          fin[6] = f6[0];
          if (k == 0) er = 4;
          else er = (f6 == ((k - 1) % 2)) ? k + 3 : k + 4;
          run_op(op, a, d, k, fin, 0, 0, er, 0);
        end

    // racing read: bit 6 settles but another bit still differs (R6)
    run_op(0, 20'h0ABCD, 16'hC3C3, 2, 16'h7F41, 1, 0, 7, 0);
    run_op(1, 20'h4F000, 16'h0000, 2, 16'h00C0, 1, 0, 7, 0);

    // never-ending operation: per-kind budgets (R7)
    run_op(0, 20'h00010, 16'hBEEF, 0, 16'h0040, 0, 1, (LP + 2) / 3, 1);
    run_op(1, 20'h00800, 16'h0000, 0, 16'h0040, 0, 1, (LS + 2) / 3, 1);
    run_op(2, 20'h08000, 16'h0000, 0, 16'h0040, 0, 1, (LB + 2) / 3, 1);
    run_op(3, 20'h00000, 16'h0000, 0, 16'h0040, 0, 1, (LC + 2) / 3, 1);

    // success right after a timeout clears the error flag (R9)
    run_op(3, 20'h00000, 16'h0000, 1, 16'hFFFF, 0, 0, 5, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule